// File: doc/BRIEF.md
# Radio Data Block Read Buffer

This block stores decoded radio data blocks in a small on-chip queue and lets a host drain them through a byte-oriented serial read port. Each stored record has an 8-bit quality byte, an 8-bit correction byte and a 16-bit data word. A producer pushes records through a valid/ready port. The host reads them in bursts framed by start and stop events, one byte per read strobe. The serial bit layer sits outside this block.

Every burst begins with a status byte. The status byte carries an interrupt flag, a flag that says more records wait behind the one shown, and a sticky overflow flag. The four bytes of the presented record follow the status byte. The head record leaves the queue only when the host takes all five bytes in one burst. Reading the status byte alone, or stopping early, leaves the queue unchanged.

Once the queue is empty, the last consumed record stays visible. A host that keeps polling can therefore receive the same record twice and must discard the duplicate. The whole record is captured when the status byte is read, so a push that lands in the middle of a burst cannot mix two records together.

Top module: `blockq_rd_top`

## Requirements
- R1: Inside a burst, successive read strobes return the bytes in this fixed order: status byte, quality byte, correction byte, data bits 15:8, data bits 7:0. Each byte appears on `rd_byte` one clock after its strobe.
- R2: The status byte has the interrupt flag in bit 0, the more-records flag in bit 1 and the overflow flag in bit 2. Bits 7:3 are always zero.
- R3: The more-records flag (status bit 1) is 1 exactly when two or more records are stored at the moment the status byte is read.
- R4: A burst that ends with a stop after one to four strobes consumes no record. The next start returns the status byte again, for the same head record.
- R5: The fifth strobe of an uninterrupted burst removes the presented record from the queue. A sixth strobe without a new start returns the status byte for the next record.
- R6: While the queue is empty, the four data bytes show the last consumed record, or all zeros if no record was ever consumed. A burst taken while the queue is empty consumes nothing.
- R7: The interrupt flag (`irq` and status bit 0) sets when the queue goes from empty to non-empty and clears when the queue becomes empty.
- R8: `push_ready` is high when the queue is not full, or when a record is removed in the same cycle. A push into a full queue with no removal is dropped and sets the overflow flag.
- R9: The overflow flag stays set until the status byte is read. It then reads as zero in the next burst, unless another record has been dropped since.
- R10: The status strobe captures the whole record. A push accepted later in the same burst changes neither its data bytes nor what the fifth strobe consumes.
- R11: Read strobes after a stop and before the next start are ignored: `rd_byte` holds its value and no record is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Producer offers a record |
| push_ready | output | 1 | Record accepted this cycle when high with push_valid |
| push_qual | input | 8 | Quality byte of the offered record |
| push_corr | input | 8 | Correction byte of the offered record |
| push_data | input | 16 | Data word of the offered record |
| rd_start | input | 1 | Start event; opens a burst at the status byte |
| rd_stop | input | 1 | Stop event; closes the burst |
| rd_strobe | input | 1 | Request the next byte of the burst |
| rd_byte | output | 8 | Byte returned for the last accepted strobe |
| irq | output | 1 | Interrupt flag: records are waiting |

## Verification
The assertions assume the host frames its reads with start and stop events. They also assume that only the block itself removes records, so the head of the queue changes only when a fifth strobe consumes it. The stimulus pairs a start with strobes or a stop in legal ways, sometimes pushes records in the middle of a burst, and cuts bursts off at every length from one to six bytes. Some strobes are sent outside any burst, and pushes arrive often enough to fill the queue past its depth.

// File: rtl/blockq_pkg.sv
// Shared types for the radio data block read buffer.
// Assumes: records are 32 bits, packed quality | correction | data word.
package blockq_pkg;

    typedef struct packed {
        logic [7:0]  qual;
        logic [7:0]  corr;
        logic [15:0] word;
    } blk_t;

    // Byte position inside a read burst; the order is visible to the host.
    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,
        SEL_QUAL = 3'd1,
        SEL_CORR = 3'd2,
        SEL_HI   = 3'd3,
        SEL_LO   = 3'd4
    } sel_e;

    // Status byte bit positions (host-decoded).
    localparam int unsigned ST_IRQ = 0;
    localparam int unsigned ST_BNE = 1;
    localparam int unsigned ST_OVF = 2;

endpackage

// File: rtl/blockq_fifo.sv
// Record queue. Holds up to DEPTH records. It keeps a copy of the last
// removed record and shows that copy while the queue is empty.
// Assumes: pop_req is only asserted for a record that was presented,
// and wr_en is already qualified by the ready logic of the top.
module blockq_fifo
    import blockq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  blk_t          wr_blk,
    input  logic          pop_req,
    output logic          full,
    output logic          pop_do,
    output logic [CW-1:0] cnt,
    output blk_t          view_blk
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    blk_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    blk_t          last_blk;

    // Queue status and the record presented to the reader.
    always_comb begin
        full     = (cnt == CW'(DEPTH));
        pop_do   = pop_req && (cnt != '0);
        view_blk = (cnt == '0) ? last_blk : mem[rd_ptr];
    end

    // Storage write; no reset needed on the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_blk;
        end
    end

    // Pointers, occupancy and the last removed record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            last_blk <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_do) begin
                rd_ptr   <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
                last_blk <= mem[rd_ptr];
            end
            cnt <= cnt + CW'(wr_en) - CW'(pop_do);
        end
    end

    // Occupancy never exceeds the depth.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // A removal without a push lowers occupancy by exactly one.
    p_pop_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_do && !wr_en) |=> (cnt == $past(cnt) - 1'b1));

    // A write is never issued into a full queue unless a removal frees a slot.
    p_no_write_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> pop_do);

    // The shown record holds while the queue stays empty and nothing is pushed.
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) && !wr_en) |=> $stable(view_blk));

endmodule

// File: rtl/blockq_flags.sv
// Interrupt and sticky overflow flags.
// Assumes: cnt is the occupancy before this cycle's push and pop.
module blockq_flags #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          wr_en,
    input  logic          pop_do,
    input  logic          drop,
    input  logic          stat_clr,
    output logic          irq,
    output logic          ovf
);

    // Interrupt: set on empty-to-filled, clear when the last record leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (wr_en && (cnt == '0)) begin
            irq <= 1'b1;
        end else if (pop_do && !wr_en && (cnt == CW'(1))) begin
            irq <= 1'b0;
        end
    end

    // Overflow: a drop sets it and wins over the status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end else if (stat_clr) begin
            ovf <= 1'b0;
        end
    end

    // Interrupt mirrors whether any record is stored.
    p_irq_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cnt != '0));

    // Overflow is sticky until a status read.
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !stat_clr) |=> ovf);

    // A drop always leaves the flag set.
    p_drop_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);

endmodule

// File: rtl/blockq_reader.sv
// Read burst sequencer. It tracks the byte position, captures the record
// on the status strobe, returns one byte per strobe and asks for a removal
// on the fifth strobe of an uninterrupted burst.
// Assumes: a start in the same cycle as a strobe opens the burst first.
module blockq_reader
    import blockq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_start,
    input  logic       rd_stop,
    input  logic       rd_strobe,
    input  blk_t       view_blk,
    input  logic       have_blk,
    input  logic       st_irq,
    input  logic       st_bne,
    input  logic       st_ovf,
    output logic [7:0] rd_byte,
    output logic       pop_req,
    output logic       stat_clr
);

    sel_e       idx;
    sel_e       idx_eff;
    logic       in_burst;
    logic       take;
    logic       snap_live;
    blk_t       snap;
    logic [7:0] status;

    // Effective position and the strobe qualification for this cycle.
    always_comb begin
        idx_eff  = rd_start ? SEL_STAT : idx;
        take     = rd_strobe && (rd_start || in_burst);
        pop_req  = take && (idx_eff == SEL_LO) && snap_live;
        stat_clr = take && (idx_eff == SEL_STAT);
        status         = '0;
        status[ST_IRQ] = st_irq;
        status[ST_BNE] = st_bne;
        status[ST_OVF] = st_ovf;
    end

    // Burst framing, position counter, record capture and byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst  <= 1'b0;
            idx       <= SEL_STAT;
            rd_byte   <= '0;
            snap      <= '0;
            snap_live <= 1'b0;
        end else begin
            if (rd_start) begin
                in_burst <= 1'b1;
            end else if (rd_stop) begin
                in_burst <= 1'b0;
            end
            if (take) begin
                unique case (idx_eff)
                    SEL_STAT: begin
                        rd_byte   <= status;
                        snap      <= view_blk;
                        snap_live <= have_blk;
                    end
                    SEL_QUAL: rd_byte <= snap.qual;
                    SEL_CORR: rd_byte <= snap.corr;
                    SEL_HI:   rd_byte <= snap.word[15:8];
                    default:  rd_byte <= snap.word[7:0];
                endcase
                idx <= (idx_eff == SEL_LO) ? SEL_STAT : sel_e'(idx_eff + 3'd1);
            end else if (rd_start) begin
                idx <= SEL_STAT;
            end
        end
    end

    // Position stays within the five-byte record.
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= SEL_LO);

    // Strobes outside a burst leave the output byte untouched.
    p_stray_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rd_start && !in_burst) |=> $stable(rd_byte));

    // A removal is only requested while a burst is open.
    p_pop_in_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> (in_burst || rd_start));

    // Status bytes keep the reserved bits at zero.
    p_status_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (rd_byte[7:3] == 5'd0));

endmodule

// File: rtl/blockq_rd_top.sv
// Top of the radio data block read buffer: ties the queue, the flags
// and the read sequencer together and forms the push handshake.
// Assumes: bit-level serial timing is handled outside; events arrive
// as single-cycle pulses.
module blockq_rd_top
    import blockq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    output logic        push_ready,
    input  logic [7:0]  push_qual,
    input  logic [7:0]  push_corr,
    input  logic [15:0] push_data,
    input  logic        rd_start,
    input  logic        rd_stop,
    input  logic        rd_strobe,
    output logic [7:0]  rd_byte,
    output logic        irq
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          full;
    logic          pop_req;
    logic          pop_do;
    logic          wr_en;
    logic          drop;
    logic          stat_clr;
    logic          ovf;
    logic [CW-1:0] cnt;
    blk_t          wr_blk;
    blk_t          view_blk;

    // Push handshake: a removal in the same cycle frees a slot.
    always_comb begin
        push_ready = !full || pop_req;
        wr_en      = push_valid && push_ready;
        drop       = push_valid && !push_ready;
        wr_blk     = '{qual: push_qual, corr: push_corr, word: push_data};
    end

    blockq_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_blk   (wr_blk),
        .pop_req  (pop_req),
        .full     (full),
        .pop_do   (pop_do),
        .cnt      (cnt),
        .view_blk (view_blk)
    );

    blockq_flags #(.CW(CW)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .wr_en    (wr_en),
        .pop_do   (pop_do),
        .drop     (drop),
        .stat_clr (stat_clr),
        .irq      (irq),
        .ovf      (ovf)
    );

    blockq_reader reader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .rd_stop   (rd_stop),
        .rd_strobe (rd_strobe),
        .view_blk  (view_blk),
        .have_blk  (cnt != '0),
        .st_irq    (irq),
        .st_bne    (cnt > CW'(1)),
        .st_ovf    (ovf),
        .rd_byte   (rd_byte),
        .pop_req   (pop_req),
        .stat_clr  (stat_clr)
    );

    // A requested removal always finds a stored record.
    p_pop_has_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> (cnt != '0));

endmodule

// File: tb/blockq_rd_top_tb_top.sv
`timescale 1ns/100ps
module blockq_rd_top_tb_top;

    localparam int unsigned DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [7:0]  push_qual = '0;
    logic [7:0]  push_corr = '0;
    logic [15:0] push_data = '0;
    logic        rd_start = 1'b0;
    logic        rd_stop = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rd_byte;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the buffer.
    logic [31:0] mq[$];
    logic [31:0] m_last = '0;
    logic [31:0] m_snap = '0;
    bit          m_live = 1'b0;
    bit          m_inb = 1'b0;
    int          m_idx = 0;
    bit          m_ovf = 1'b0;
    logic [7:0]  m_byte = '0;

    always #2.5 clk = ~clk;

    blockq_rd_top #(.DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_qual  (push_qual),
        .push_corr  (push_corr),
        .push_data  (push_data),
        .rd_start   (rd_start),
        .rd_stop    (rd_stop),
        .rd_strobe  (rd_strobe),
        .rd_byte    (rd_byte),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Byte of a record at a burst position (1..4), per R1.
    function automatic logic [7:0] rec_byte(input logic [31:0] r, input int pos);
        case (pos)
            1:       return r[31:24];
            2:       return r[23:16];
            3:       return r[15:8];
            default: return r[7:0];
        endcase
    endfunction

    // Status byte from the model, per R2/R3/R7.
    function automatic logic [7:0] stat_byte(input int n, input bit ov);
        return {5'b0, ov, (n > 1), (n != 0)};
    endfunction

    // One clock: drive at the falling edge, check afterwards.
    task automatic step(input bit pv, input logic [31:0] pd, input bit st,
                        input bit sp, input bit sb, input string tag);
        int  ie;
        bit  act, pop, rdy, take;
        push_valid = pv;
        {push_qual, push_corr, push_data} = pd;
        rd_start = st; rd_stop = sp; rd_strobe = sb;
        ie   = st ? 0 : m_idx;
        act  = st || m_inb;
        take = sb && act;
        pop  = take && (ie == 4) && m_live;
        rdy  = (mq.size() < DEPTH) || pop;
        #1;
        check("R8 push_ready", push_ready, rdy);
        if (take) begin
            if (ie == 0) begin
                m_byte = stat_byte(mq.size(), m_ovf);
                m_snap = (mq.size() != 0) ? mq[0] : m_last;
                m_live = (mq.size() != 0);
            end else begin
                m_byte = rec_byte(m_snap, ie);
            end
            m_idx = (ie == 4) ? 0 : ie + 1;
        end else if (st) begin
            m_idx = 0;
        end
        if (st) m_inb = 1'b1;
        else if (sp) m_inb = 1'b0;
        if (pop) m_last = mq.pop_front();
        if (pv && rdy) mq.push_back(pd);
        if (pv && !rdy) m_ovf = 1'b1;
        else if (take && ie == 0) m_ovf = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " rd_byte"}, rd_byte, m_byte);
        check("R7 irq", irq, mq.size() != 0);
        push_valid = 1'b0; rd_start = 1'b0; rd_stop = 1'b0; rd_strobe = 1'b0;
    endtask

    // Burst of n strobes; optional pushes with given odds while reading.
    task automatic burst(input int n, input int push_odds, input string tag);
        step(0, 0, 1, 0, 1, tag);
        for (int i = 1; i < n; i++) begin
            bit pv = (push_odds != 0) && (($urandom % push_odds) == 0);
            step(pv, $urandom, 0, 0, 1, tag);
        end
        step(0, 0, 0, 1, 0, tag);
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        #900000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset irq", irq, 0);
        check("R6 reset rd_byte", rd_byte, 0);
        check("R8 reset push_ready", push_ready, 1);

        // Empty queue: zeros, nothing consumed.
        burst(5, 0, "R6");
        // Three records; a status-only read, then partial bursts.
        step(1, 32'hA1A2A3A4, 0, 0, 0, "R7");
        step(1, 32'hB1B2B3B4, 0, 0, 0, "R3");
        step(1, 32'hC1C2C3C4, 0, 0, 0, "R3");
        burst(1, 0, "R4");
        check("R3 status bne", rd_byte, 8'h03);
        burst(3, 0, "R4");
        burst(5, 0, "R1");
        check("R1 last byte of A", rd_byte, 8'hA4);
        // Wrap into the next record without a restart.
        burst(10, 0, "R5");
        check("R5 queue drained", irq, 0);
        // Duplicate of the last record while empty.
        burst(5, 0, "R6");
        check("R6 duplicate low byte", rd_byte, 8'hC4);
        // Stray strobes after a stop.
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R11");
        check("R11 held byte", rd_byte, 8'hC4);
        // Push mid-burst on an empty queue: no tearing, no removal.
        step(0, 0, 1, 0, 1, "R10");
        step(1, 32'hD1D2D3D4, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");
        check("R10 untorn low byte", rd_byte, 8'hC4);
        step(0, 0, 0, 1, 0, "R10");
        burst(5, 0, "R10");
        check("R10 new record consumed", rd_byte, 8'hD4);
        // Overflow: fill past depth, then status reads.
        for (int i = 0; i <= DEPTH; i++) step(1, 32'h1000 + i, 0, 0, 0, "R8");
        burst(1, 0, "R9");
        check("R9 overflow shown", rd_byte, 8'h07);
        burst(1, 0, "R9");
        check("R9 overflow cleared", rd_byte, 8'h03);
        // Push into a full queue on the consuming strobe is accepted.
        step(0, 0, 1, 0, 1, "R8");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, "R8");
        step(1, 32'hEEEE0001, 0, 0, 1, "R8");
        step(0, 0, 0, 1, 0, "R8");
        check("R9 no overflow on freed slot", 32'(m_ovf), 0);

        // Random mix.
        for (int it = 0; it < 600; it++) begin
            int r = $urandom % 6;
            case (r)
                0, 1: step(1, $urandom, 0, 0, 0, "R8");
                2:    burst(5, 3, "R1");
                3:    burst(1 + ($urandom % 4), 4, "R4");
                4:    burst(6 + ($urandom % 5), 5, "R5");
                default: step(0, 0, 0, $urandom % 2, $urandom % 2, "R11");
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule